// File: doc/BRIEF.md
# Fetch Block Header Slot Controller

This block sits between instruction fetch and the slot decoders of a wide-issue front end. Every cycle it can accept one aligned 256-bit fetch block, which is eight 32-bit slots, together with the current 16 predicate flags. It scans the header run at the front of the block and turns it into three per-slot masks. The first mask says which slots the decoders should look at. The second says which slots must start a new issue group. The third says which slots are allowed to execute under flag predication. It also reports where a 48-bit instruction sits, if there is one, and hands out that instruction's trailing 16 bits.

A header run may only begin at slot 0 and must be contiguous. The header opcodes, the field positions and the length of the scanned run are all parameters. Three header kinds are supported:

- a register-operate instruction that also holds a trailing-data count;
- a parallel-issue header that carries break bits and predication fields;
- a wide-instruction header that carries a slot position, a 16-bit tail and its own trailing-data count.

All results are registered, so they appear exactly one clock after the block is presented.

Top module: `blk_hdr_ctrl`

## Requirements
- R1: When `blk_valid` is high at a rising edge, `out_valid` and every result for that block appear after that edge. When `blk_valid` is low, `out_valid` goes low after the edge and all other outputs keep their previous values.
- R2: With `rst` high at a rising edge, every output is zero after that edge.
- R3: A slot's top four bits name its kind: 1100 is an operate header, 1101 is an issue/predicate header, 1011 is a wide header, and any other value is an instruction. Slot s sits at `blk_data[255-32*s -: 32]`. Headers are recognised only in a contiguous run from slot 0, at most 3 slots long. The run ends at the first instruction slot, and a header-looking word after that point is treated as an instruction.
- R4: A block with no header gives `dec_en` all ones, `brk` all zeros and `pred_ok` all ones. Bit i of each mask belongs to slot i.
- R5: A trailing-data count N is taken from bits [2:0] of an operate header or bits [24:22] of a wide header. It clears `dec_en` for the last N slots. When the run holds several counts, the last one in the run is used.
- R6: An operate header slot keeps its decode enable. Issue/predicate header slots and wide header slots have decode disabled.
- R7: The break bits are bits [27:21] of the issue/predicate header, with bit 27 for slot 1 and bit 21 for slot 7. A set bit sets `brk` for that slot. `brk[0]` is always 0.
- R8: In the issue/predicate header, bits [20:17] select a flag, bit 16 is the sense, and bits [15:9] mark the predicated slots (bit 15 is slot 1). A predicated slot passes when the selected flag XOR the sense is 1. Slots that are not predicated, and slot 0, always pass.
- R9: In a wide header, bits [27:25] give a slot position and bits [15:0] give the tail. `wide_vld` is set when the position is 1 to 7, and then `wide_slot` and `wide_tail` report the position and the tail. A position of 0 gives `wide_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | Fetch block present this cycle |
| blk_data | input | 256 | Fetch block, slot 0 in the top 32 bits |
| flags | input | 16 | Predicate flag bits |
| out_valid | output | 1 | Registered results are for a new block |
| dec_en | output | 8 | Per-slot decode enable |
| brk | output | 8 | Per-slot issue-group break |
| pred_ok | output | 8 | Per-slot predicate pass |
| wide_vld | output | 1 | A 48-bit instruction is present |
| wide_slot | output | 3 | Slot holding the first 32 bits of that instruction |
| wide_tail | output | 16 | Last 16 bits of that instruction |

## Verification
Every result of this block is due exactly one rising edge after the block and flags are driven. The bench drives on the falling edge, moves one falling edge forward, and only then compares all outputs against its reference model. An idle cycle is checked the same way: one edge after `blk_valid` drops, `out_valid` must be low while the masks and the wide fields still show the previous block.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [1:0] {
    HK_INSN = 2'd0,
    HK_OPER = 2'd1,
    HK_ISSUE = 2'd2,
    HK_WIDE = 2'd3
  } hdr_kind_e;
endpackage

// File: rtl/bh_hdr_scan.sv
module bh_hdr_scan
  import bh_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int SLOT_W   = 32,
  parameter int FLAG_N   = 16,
  parameter int MAX_HDR  = 3,
  parameter int OPC_W    = 4,
  parameter logic [OPC_W-1:0] OPC_OPER  = 4'b1100,
  parameter logic [OPC_W-1:0] OPC_ISSUE = 4'b1101,
  parameter logic [OPC_W-1:0] OPC_WIDE  = 4'b1011,
  parameter int CNT_LSB_OPER = 0,
  parameter int CNT_LSB_WIDE = 22,
  parameter int BRK_MSB   = 27,
  parameter int FSEL_LSB  = 17,
  parameter int SENSE_BIT = 16,
  parameter int PRED_MSB  = 15,
  parameter int POS_LSB   = 25,
  parameter int TAIL_W    = 16,
  localparam int BLK_W  = SLOTS * SLOT_W,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int FSEL_W = $clog2(FLAG_N)
) (
  input  logic [BLK_W-1:0]  blk,
  output logic [SLOTS-1:0]  hdr_nodec,
  output logic [IDX_W-1:0]  rsv_cnt,
  output logic              issue_on,
  output logic [SLOTS-2:0]  brk_f,
  output logic [FSEL_W-1:0] fsel,
  output logic              sense,
  output logic [SLOTS-2:0]  pred_f,
  output logic              wide_on,
  output logic [IDX_W-1:0]  wide_pos,
  output logic [TAIL_W-1:0] wide_tail
);
  always_comb begin
    logic in_run;
    logic [SLOT_W-1:0] word;
    hdr_kind_e kind;
    hdr_nodec = '0;
    rsv_cnt   = '0;
    issue_on  = 1'b0;
    brk_f     = '0;
    fsel      = '0;
    sense     = 1'b0;
    pred_f    = '0;
    wide_on   = 1'b0;
    wide_pos  = '0;
    wide_tail = '0;
    in_run    = 1'b1;
    for (int s = 0; s < MAX_HDR; s++) begin
      word = blk[BLK_W-1-s*SLOT_W -: SLOT_W];
      if (word[SLOT_W-1 -: OPC_W] == OPC_OPER)       kind = HK_OPER;
      else if (word[SLOT_W-1 -: OPC_W] == OPC_ISSUE) kind = HK_ISSUE;
      else if (word[SLOT_W-1 -: OPC_W] == OPC_WIDE)  kind = HK_WIDE;
      else                                           kind = HK_INSN;
      if (in_run) begin
        case (kind)
          HK_OPER: rsv_cnt = word[CNT_LSB_OPER +: IDX_W];
          HK_ISSUE: begin
            hdr_nodec[s] = 1'b1;
            issue_on     = 1'b1;
            brk_f        = word[BRK_MSB -: SLOTS-1];
            fsel         = word[FSEL_LSB +: FSEL_W];
            sense        = word[SENSE_BIT];
            pred_f       = word[PRED_MSB -: SLOTS-1];
          end
          HK_WIDE: begin
            hdr_nodec[s] = 1'b1;
            rsv_cnt      = word[CNT_LSB_WIDE +: IDX_W];
            wide_pos     = word[POS_LSB +: IDX_W];
            wide_on      = (word[POS_LSB +: IDX_W] != '0);
            wide_tail    = word[TAIL_W-1:0];
          end
          default: in_run = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bh_slot_mask.sv
module bh_slot_mask #(
  parameter int SLOTS  = 8,
  parameter int FLAG_N = 16,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int FSEL_W = $clog2(FLAG_N)
) (
  input  logic [SLOTS-1:0]  hdr_nodec,
  input  logic [IDX_W-1:0]  rsv_cnt,
  input  logic              issue_on,
  input  logic [SLOTS-2:0]  brk_f,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              sense,
  input  logic [SLOTS-2:0]  pred_f,
  input  logic [FLAG_N-1:0] flags,
  output logic [SLOTS-1:0]  dec_en,
  output logic [SLOTS-1:0]  brk,
  output logic [SLOTS-1:0]  pred_ok
);
  logic cond_pass;
  assign cond_pass = flags[fsel] ^ sense;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic reserved;
    assign reserved  = (g + int'(rsv_cnt)) >= SLOTS;
    assign dec_en[g] = ~hdr_nodec[g] & ~reserved;
    if (g == 0) begin : g_lead
      assign brk[g]     = 1'b0;
      assign pred_ok[g] = 1'b1;
    end else begin : g_rest
      assign brk[g]     = issue_on & brk_f[SLOTS-1-g];
      assign pred_ok[g] = ~(issue_on & pred_f[SLOTS-1-g]) | cond_pass;
    end
  end
endmodule

// File: rtl/blk_hdr_ctrl.sv
module blk_hdr_ctrl #(
  parameter int SLOTS   = 8,
  parameter int SLOT_W  = 32,
  parameter int FLAG_N  = 16,
  parameter int MAX_HDR = 3,
  parameter int OPC_W   = 4,
  parameter logic [OPC_W-1:0] OPC_OPER  = 4'b1100,
  parameter logic [OPC_W-1:0] OPC_ISSUE = 4'b1101,
  parameter logic [OPC_W-1:0] OPC_WIDE  = 4'b1011,
  parameter int CNT_LSB_OPER = 0,
  parameter int TAIL_W = 16,
  localparam int BLK_W = SLOTS * SLOT_W,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_valid,
  input  logic [BLK_W-1:0]  blk_data,
  input  logic [FLAG_N-1:0] flags,
  output logic              out_valid,
  output logic [SLOTS-1:0]  dec_en,
  output logic [SLOTS-1:0]  brk,
  output logic [SLOTS-1:0]  pred_ok,
  output logic              wide_vld,
  output logic [IDX_W-1:0]  wide_slot,
  output logic [TAIL_W-1:0] wide_tail
);
  localparam int FSEL_W = $clog2(FLAG_N);

  logic [SLOTS-1:0]  hdr_nodec;
  logic [IDX_W-1:0]  rsv_cnt;
  logic              issue_on;
  logic [SLOTS-2:0]  brk_f;
  logic [FSEL_W-1:0] fsel;
  logic              sense;
  logic [SLOTS-2:0]  pred_f;
  logic              wide_on;
  logic [IDX_W-1:0]  wide_pos;
  logic [TAIL_W-1:0] tail_c;
  logic [SLOTS-1:0]  dec_c, brk_c, pok_c;

  bh_hdr_scan #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .FLAG_N(FLAG_N), .MAX_HDR(MAX_HDR),
    .OPC_W(OPC_W), .OPC_OPER(OPC_OPER), .OPC_ISSUE(OPC_ISSUE),
    .OPC_WIDE(OPC_WIDE), .CNT_LSB_OPER(CNT_LSB_OPER), .TAIL_W(TAIL_W)
  ) u_scan (
    .blk(blk_data), .hdr_nodec(hdr_nodec), .rsv_cnt(rsv_cnt),
    .issue_on(issue_on), .brk_f(brk_f), .fsel(fsel), .sense(sense),
    .pred_f(pred_f), .wide_on(wide_on), .wide_pos(wide_pos),
    .wide_tail(tail_c)
  );

  bh_slot_mask #(.SLOTS(SLOTS), .FLAG_N(FLAG_N)) u_mask (
    .hdr_nodec(hdr_nodec), .rsv_cnt(rsv_cnt), .issue_on(issue_on),
    .brk_f(brk_f), .fsel(fsel), .sense(sense), .pred_f(pred_f),
    .flags(flags), .dec_en(dec_c), .brk(brk_c), .pred_ok(pok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dec_en    <= '0;
      brk       <= '0;
      pred_ok   <= '0;
      wide_vld  <= 1'b0;
      wide_slot <= '0;
      wide_tail <= '0;
    end else begin
      out_valid <= blk_valid;
      if (blk_valid) begin
        dec_en    <= dec_c;
        brk       <= brk_c;
        pred_ok   <= pok_c;
        wide_vld  <= wide_on;
        wide_slot <= wide_pos;
        wide_tail <= tail_c;
      end
    end
  end

  logic [OPC_W-1:0] nib0, nib1;
  assign nib0 = blk_data[BLK_W-1 -: OPC_W];
  assign nib1 = blk_data[BLK_W-1-SLOT_W -: OPC_W];

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    blk_valid |=> out_valid);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !blk_valid |=> (!out_valid && $stable(dec_en) && $stable(brk) && $stable(wide_tail)));
  a_r4_plain_block: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && nib0 != OPC_OPER && nib0 != OPC_ISSUE && nib0 != OPC_WIDE)
    |=> (dec_en == '1 && brk == '0 && pred_ok == '1 && !wide_vld));
  a_r6_issue_hdr_hidden: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && nib0 == OPC_ISSUE) |=> !dec_en[0]);
  a_r5_full_reserve: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && nib0 == OPC_OPER && nib1 != OPC_OPER && nib1 != OPC_ISSUE &&
     nib1 != OPC_WIDE &&
     blk_data[BLK_W-SLOT_W+CNT_LSB_OPER +: IDX_W] == IDX_W'(SLOTS-1))
    |=> (dec_en == SLOTS'(1)));
  a_r9_wide_slot_nonzero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wide_vld) |-> (wide_slot != '0));
endmodule

// File: tb/sim_blk_hdr_ctrl.sv
`timescale 1ns/1ps
module sim_blk_hdr_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic blk_valid;
  logic [255:0] blk_data;
  logic [15:0] flags;
  logic out_valid, wide_vld;
  logic [7:0] dec_en, brk, pred_ok;
  logic [2:0] wide_slot;
  logic [15:0] wide_tail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] e_dec, e_brk, e_pok;
  logic e_wv;
  logic [2:0] e_ws;
  logic [15:0] e_wt;

  always #2.5 clk = ~clk;

  blk_hdr_ctrl u0 (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .blk_data(blk_data),
    .flags(flags), .out_valid(out_valid), .dec_en(dec_en), .brk(brk),
    .pred_ok(pred_ok), .wide_vld(wide_vld), .wide_slot(wide_slot),
    .wide_tail(wide_tail)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] oper_h(input int cnt, input logic [27:0] lo);
    return {4'hC, lo[27:3], 3'(cnt)};
  endfunction
  function automatic logic [31:0] issue_h(input logic [6:0] b, input logic [3:0] sel,
                                          input logic s, input logic [6:0] p);
    return {4'hD, b, sel, s, p, 9'h055};
  endfunction
  function automatic logic [31:0] wide_h(input int pos, input int cnt, input logic [15:0] t);
    return {4'hB, 3'(pos), 3'(cnt), 6'h2A, t};
  endfunction
  function automatic logic [31:0] insn(input int i);
    return 32'h0123_4560 + i;
  endfunction

  // Reference model, built from the requirements
  task automatic ref_model(input logic [255:0] b, input logic [15:0] f);
    int rsv = 0;
    logic [6:0] bm = '0, pm = '0;
    int sel = 0;
    logic sen = 0;
    e_dec = 8'hFF; e_brk = 8'h00; e_pok = 8'hFF;
    e_wv = 0; e_ws = 0; e_wt = 0;
    for (int s = 0; s < 3; s++) begin
      logic [31:0] w;
      w = b[255-32*s -: 32];
      if (w[31:28] == 4'hC) rsv = int'(w[2:0]);
      else if (w[31:28] == 4'hD) begin
        e_dec[s] = 0; bm = w[27:21]; sel = int'(w[20:17]); sen = w[16]; pm = w[15:9];
      end else if (w[31:28] == 4'hB) begin
        e_dec[s] = 0; rsv = int'(w[24:22]); e_ws = w[27:25];
        e_wv = (w[27:25] != 0); e_wt = w[15:0];
      end else break;
    end
    for (int k = 0; k < rsv; k++) e_dec[7-k] = 0;
    for (int i = 1; i < 8; i++) begin
      e_brk[i] = bm[7-i];
      if (pm[7-i]) e_pok[i] = f[sel] ^ sen;
    end
  endtask

  task automatic compare(input string tag);
    check(out_valid === 1'b1, "R1", "out_valid", 32'(out_valid), 1);
    check(dec_en === e_dec, tag, "dec_en", 32'(dec_en), 32'(e_dec));
    check(brk === e_brk, tag, "brk", 32'(brk), 32'(e_brk));
    check(pred_ok === e_pok, tag, "pred_ok", 32'(pred_ok), 32'(e_pok));
    check(wide_vld === e_wv, tag, "wide_vld", 32'(wide_vld), 32'(e_wv));
    check(wide_slot === e_ws, tag, "wide_slot", 32'(wide_slot), 32'(e_ws));
    check(wide_tail === e_wt, tag, "wide_tail", 32'(wide_tail), 32'(e_wt));
  endtask

  // Drives on a falling edge, compares one edge later
  task automatic apply(input logic [255:0] b, input logic [15:0] f, input string tag);
    blk_valid = 1; blk_data = b; flags = f;
    ref_model(b, f);
    @(negedge clk);
    blk_valid = 0;
    compare(tag);
  endtask

  function automatic logic [31:0] rnd_word();
    int k = int'($urandom % 5);
    case (k)
      0: return oper_h(int'($urandom % 8), 28'($urandom));
      1: return issue_h(7'($urandom), 4'($urandom), 1'($urandom), 7'($urandom));
      2: return wide_h(int'($urandom % 8), int'($urandom % 8), 16'($urandom));
      default: return {1'b0, 31'($urandom)};
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; blk_valid = 0; blk_data = '0; flags = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(out_valid === 0, "R2", "out_valid", 32'(out_valid), 0);
    check(dec_en === 0 && brk === 0 && pred_ok === 0, "R2", "masks",
          {8'h0, dec_en, brk, pred_ok}, 0);
    check(wide_vld === 0 && wide_slot === 0 && wide_tail === 0, "R2", "wide",
          {wide_vld, 12'h0, wide_slot, wide_tail}, 0);
    rst = 0;
    @(negedge clk);

    apply({insn(0), insn(1), insn(2), insn(3), insn(4), insn(5), insn(6), insn(7)},
          16'h0, "R4");
    apply({oper_h(2, 28'h0ABC000), insn(1), insn(2), insn(3), insn(4), insn(5),
           insn(6), insn(7)}, 16'h0, "R5");
    apply({oper_h(7, 28'h0), insn(1), insn(2), insn(3), insn(4), insn(5),
           insn(6), insn(7)}, 16'h0, "R6");
    apply({issue_h(7'b1010101, 4'd5, 1'b0, 7'b1100110), insn(1), insn(2), insn(3),
           insn(4), insn(5), insn(6), insn(7)}, 16'h0020, "R7");
    apply({issue_h(7'b0000001, 4'd5, 1'b0, 7'b1100110), insn(1), insn(2), insn(3),
           insn(4), insn(5), insn(6), insn(7)}, 16'hFFDF, "R8");
    apply({issue_h(7'b0, 4'd12, 1'b1, 7'b0111111), insn(1), insn(2), insn(3),
           insn(4), insn(5), insn(6), insn(7)}, 16'h0000, "R8");
    apply({wide_h(3, 1, 16'hBEEF), insn(1), insn(2), insn(3), insn(4), insn(5),
           insn(6), insn(7)}, 16'h0, "R9");
    apply({wide_h(0, 0, 16'h1234), insn(1), insn(2), insn(3), insn(4), insn(5),
           insn(6), insn(7)}, 16'h0, "R9");
    apply({oper_h(3, 28'h0), issue_h(7'b1000000, 4'd0, 1'b1, 7'b0000011),
           wide_h(5, 1, 16'hCAFE), insn(3), insn(4), insn(5), insn(6), insn(7)},
          16'h0001, "R5");
    apply({insn(0), issue_h(7'b1111111, 4'd0, 1'b1, 7'b1111111), wide_h(2, 4, 16'h7),
           insn(3), insn(4), insn(5), insn(6), insn(7)}, 16'h0, "R3");
    apply({oper_h(1, 28'h0), oper_h(0, 28'h0), issue_h(7'b0, 4'd0, 1'b0, 7'b0),
           wide_h(6, 2, 16'h5555), insn(4), insn(5), insn(6), insn(7)}, 16'h0, "R3");

    // R1 idle cycle: out_valid low, results held
    blk_data = ~blk_data; flags = ~flags;
    @(negedge clk);
    check(out_valid === 0, "R1", "idle out_valid", 32'(out_valid), 0);
    check(dec_en === e_dec && brk === e_brk && pred_ok === e_pok, "R1", "idle hold",
          {8'h0, dec_en, brk, pred_ok}, {8'h0, e_dec, e_brk, e_pok});
    check(wide_tail === e_wt, "R1", "idle tail", 32'(wide_tail), 32'(e_wt));

    for (int n = 0; n < 60; n++) begin
      logic [255:0] b;
      for (int s = 0; s < 8; s++) b[255-32*s -: 32] = rnd_word();
      apply(b, 16'($urandom), "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule